// File: doc/BRIEF.md
# Listen-Before-Transmit Access Controller

This block stands between a packet transmitter and a half-duplex radio. It decides the cycle in which a pending transmission may begin. A host raises a transmit request and holds it. The controller then applies one of four collision-avoidance policies, chosen by two mode bits:

- start at once;
- wait a computed polling slot;
- listen until the channel is clear;
- listen, and on a busy channel back off for a random number of milliseconds before listening again.

While it senses the channel, the controller enables the receiver. A separate detector reports a channel-busy level to the block. When the controller decides to transmit, it emits a single-cycle go strobe.

All waiting is measured in pulses of a 100 µs timebase tick, so one millisecond is ten ticks. The slot wait depends on the unit's slot number and on the preamble, packet and turnaround timing. The wait is rounded up to a whole tick. The random back-off comes from a free-running 16-bit LFSR whose low bits are masked to the back-off exponent.

There is no data stream at this block's edge, so no valid/ready handshake applies. The request is a level that the host holds until it has seen the go strobe. The go strobe lasts one cycle, and the receiver enable is a plain level.

Top module: `lbt_access_ctrl`

## Requirements
- R1: After reset, and until a request is seen, `rx_en` and `tx_go` are both 0.
- R2: With `mode_listen`=0 and `mode_delay`=0, `tx_go` is 1 in the cycle after the first clock edge that samples `tx_req` high. `rx_en` stays 0 in this mode.
- R3: `tx_go` is high for exactly one cycle and fires at most once per request. A new strobe needs `tx_req` to go low and then high again.
- R4: With `mode_listen`=0 and `mode_delay`=1, the wait is W tick pulses, counted after the edge that first samples the request. W = ceil(slot × (preamble + 6×bytes + 6×turnaround + 10) / 2), where turnaround is in 0.1 ms units. `tx_go` rises in the cycle after the W-th tick. A slot of 0 behaves as in R2. Cycles without a tick do not advance the wait. `rx_en` stays 0 throughout.
- R5: With `mode_listen`=1 and `mode_delay`=0, `rx_en` is 1 while the channel is sensed. No `tx_go` follows an edge that samples `chan_busy`=1. `tx_go` rises in the cycle after an edge that samples `chan_busy`=0.
- R6: With both mode bits at 1, an edge that samples a busy channel drops `rx_en`. The block then waits r×10 ticks, where r is the LFSR value masked to `backoff_exp` bits (0 ≤ r ≤ 2^N−1), and then senses again with `rx_en`=1.
- R7: With both mode bits at 1 and `backoff_exp`=0, a busy channel gives no back-off. `rx_en` stays 1 and the block re-samples the channel on every cycle.
- R8: An edge that samples `tx_req`=0 in any state returns the block to idle. In the next cycle `rx_en`=0 and `tx_go`=0, and any wait in progress is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_req | input | 1 | Level: a transmission is pending |
| chan_busy | input | 1 | Preamble or data detected on the channel |
| mode_listen | input | 1 | 1 = sense the channel before sending |
| mode_delay | input | 1 | 1 = slot wait (no listen) or random back-off (listen) |
| slot_num | input | 8 | Polling slot index, 0 to 255 |
| backoff_exp | input | 3 | Back-off exponent N, wait up to 2^N−1 ms |
| preamble_len | input | 8 | Preamble length in cycles |
| pkt_bytes | input | 5 | Packet length in bytes |
| turnaround | input | 8 | TX/RX change-over delay in 0.1 ms units |
| tick_100us | input | 1 | One-cycle pulse every 100 µs |
| rx_en | output | 1 | Receiver enable while sensing |
| tx_go | output | 1 | One-cycle strobe: start transmitting now |

## Verification
The slot test drives ticks only on every third cycle and uses an odd half-tick product. A design that counts clock cycles instead of ticks, or that truncates the slot length instead of rounding it up, sends one tick early or late. A zero slot must go at once and not wrap to a huge wait.

The back-off test times each low period of `rx_en` while the channel stays busy. A design that drops the ×10 scaling, or that ignores the exponent mask, produces periods off the 10-tick grid or above 70 ticks. With a zero exponent, the receiver must never drop.

The abort tests release the request in the middle of a slot wait and in the middle of sensing. A design that keeps its pending state would later fire a stray strobe.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SLOT    = 3'd1,
    ST_SENSE   = 3'd2,
    ST_BACKOFF = 3'd3,
    ST_GO      = 3'd4,
    ST_HOLD    = 3'd5
  } lbt_state_e;

  localparam int unsigned TICKS_PER_MS = 10;
endpackage

// File: rtl/lbt_slot_calc.sv
// Slot wait in 100 us ticks, rounded up:
//   ceil(slot * (pre + 6*bytes + 6*ta + 10) / 2)
module lbt_slot_calc #(
  parameter int unsigned SLOT_W = 8,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned TA_W   = 8,
  parameter int unsigned CNT_W  = 20
) (
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [PRE_W-1:0]  preamble_len,
  input  logic [LEN_W-1:0]  pkt_bytes,
  input  logic [TA_W-1:0]   turnaround,
  output logic [CNT_W-1:0]  slot_ticks
);
  localparam int unsigned HALF_W = CNT_W + 1;

  logic [HALF_W-1:0] per_slot_half;
  logic [HALF_W-1:0] total_half;

  always_comb begin
    per_slot_half = HALF_W'(preamble_len)
                  + HALF_W'(6) * HALF_W'(pkt_bytes)
                  + HALF_W'(6) * HALF_W'(turnaround)
                  + HALF_W'(10);
    total_half    = HALF_W'(slot_num) * per_slot_half;
    slot_ticks    = CNT_W'((total_half + HALF_W'(1)) >> 1);
  end
endmodule

// File: rtl/lbt_lfsr.sv
module lbt_lfsr #(
  parameter int unsigned W     = 16,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic fb;

  // Taps 16,14,13,11 give a maximal-length sequence for W = 16.
  assign fb = value[W-1] ^ value[W-3] ^ value[W-4] ^ value[W-6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= SEED;
    else        value <= {value[W-2:0], fb};
  end

  // R6
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    value != '0);
endmodule

// File: rtl/lbt_tick_timer.sv
module lbt_tick_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  assign expire = tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - CNT_W'(1);
  end

  // R4
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt));

  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> cnt <= $past(cnt));
endmodule

// File: rtl/lbt_access_ctrl.sv
module lbt_access_ctrl #(
  parameter int unsigned SLOT_W = 8,
  parameter int unsigned PRE_W  = 8,
  parameter int unsigned LEN_W  = 5,
  parameter int unsigned TA_W   = 8,
  parameter int unsigned EXP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_req,
  input  logic              chan_busy,
  input  logic              mode_listen,
  input  logic              mode_delay,
  input  logic [SLOT_W-1:0] slot_num,
  input  logic [EXP_W-1:0]  backoff_exp,
  input  logic [PRE_W-1:0]  preamble_len,
  input  logic [LEN_W-1:0]  pkt_bytes,
  input  logic [TA_W-1:0]   turnaround,
  input  logic              tick_100us,
  output logic              rx_en,
  output logic              tx_go
);
  import lbt_pkg::*;

  localparam int unsigned MAXF_W  = (PRE_W > TA_W) ? ((PRE_W > LEN_W) ? PRE_W : LEN_W)
                                                   : ((TA_W > LEN_W) ? TA_W : LEN_W);
  localparam int unsigned CNT_W   = SLOT_W + MAXF_W + 4;
  localparam int unsigned RAND_W  = (1 << EXP_W) - 1;
  localparam int unsigned LFSR_W  = 16;

  lbt_state_e        state, state_nx;
  logic [CNT_W-1:0]  slot_ticks, bo_ticks, load_val;
  logic [LFSR_W-1:0] lfsr_val;
  logic [RAND_W-1:0] rand_mask, rand_val;
  logic              load, expire;

  lbt_slot_calc #(
    .SLOT_W(SLOT_W), .PRE_W(PRE_W), .LEN_W(LEN_W), .TA_W(TA_W), .CNT_W(CNT_W)
  ) u_slot (
    .slot_num(slot_num), .preamble_len(preamble_len),
    .pkt_bytes(pkt_bytes), .turnaround(turnaround), .slot_ticks(slot_ticks)
  );

  lbt_lfsr #(.W(LFSR_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .value(lfsr_val));

  lbt_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .tick(tick_100us), .expire(expire)
  );

  // Random back-off: LFSR low bits masked to N bits, scaled to ticks.
  always_comb begin
    rand_mask = RAND_W'((1 << backoff_exp) - 1);
    rand_val  = lfsr_val[RAND_W-1:0] & rand_mask;
    bo_ticks  = CNT_W'(rand_val) * CNT_W'(TICKS_PER_MS);
  end

  always_comb begin
    state_nx = state;
    load     = 1'b0;
    load_val = slot_ticks;
    unique case (state)
      ST_IDLE: if (tx_req) begin
        unique case ({mode_listen, mode_delay})
          2'b00: state_nx = ST_GO;
          2'b01: if (slot_ticks == '0) state_nx = ST_GO;
                 else begin load = 1'b1; state_nx = ST_SLOT; end
          default: state_nx = ST_SENSE;
        endcase
      end
      ST_SLOT:    if (expire) state_nx = ST_GO;
      ST_SENSE: begin
        if (!chan_busy)               state_nx = ST_GO;
        else if (mode_delay && bo_ticks != '0) begin
          load     = 1'b1;
          load_val = bo_ticks;
          state_nx = ST_BACKOFF;
        end
      end
      ST_BACKOFF: if (expire) state_nx = ST_SENSE;
      ST_GO:      state_nx = ST_HOLD;
      ST_HOLD:    state_nx = ST_HOLD;
      default:    state_nx = ST_IDLE;
    endcase
    if (!tx_req) begin
      state_nx = ST_IDLE;
      load     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  assign rx_en = (state == ST_SENSE);
  assign tx_go = (state == ST_GO);

  // R3
  go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_go |=> !tx_go);

  // R5
  sense_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !chan_busy && tx_req) |=> tx_go);

  // R5
  busy_no_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && chan_busy) |=> !tx_go);

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |=> (!tx_go && !rx_en));

  // R7
  zero_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && chan_busy && tx_req && mode_delay && backoff_exp == '0) |=> rx_en);
endmodule

// File: tb/tb_lbt_access_ctrl.sv
`timescale 1ns/1ps
module tb_lbt_access_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_req = 1'b0, chan_busy = 1'b0;
  logic       mode_listen = 1'b0, mode_delay = 1'b0;
  logic [7:0] slot_num = '0, preamble_len = '0, turnaround = 8'd30;
  logic [2:0] backoff_exp = 3'd3;
  logic [4:0] pkt_bytes = '0;
  logic       tick_100us = 1'b0;
  logic       rx_en, tx_go;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  lbt_access_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .chan_busy(chan_busy),
    .mode_listen(mode_listen), .mode_delay(mode_delay), .slot_num(slot_num),
    .backoff_exp(backoff_exp), .preamble_len(preamble_len), .pkt_bytes(pkt_bytes),
    .turnaround(turnaround), .tick_100us(tick_100us), .rx_en(rx_en), .tx_go(tx_go)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic release_req();
    @(negedge clk);
    tx_req = 1'b0; chan_busy = 1'b0; tick_100us = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(rx_en == 1'b0, "R1 rx_en", rx_en, 0);
    chk(tx_go == 1'b0, "R1 tx_go", tx_go, 0);
  endtask

  task automatic t_immediate();
    int gos = 0, rx = 0;
    mode_listen = 0; mode_delay = 0;
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk);
    chk(tx_go == 1'b1, "R2 go next cycle", tx_go, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_go) gos++;
      if (rx_en) rx++;
    end
    chk(gos == 0, "R3 single strobe per request", gos, 0);
    chk(rx == 0, "R2 rx_en idle", rx, 0);
    release_req();
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk);
    chk(tx_go == 1'b1, "R3 re-arm after release", tx_go, 1);
    release_req();
  endtask

  task automatic t_slot(input int s, input int pre, input int by, input int ta);
    int expw, n = 0, rx = 0;
    bit seen = 0;
    expw = (s * (pre + 6*by + 6*ta + 10) + 1) / 2;
    mode_listen = 0; mode_delay = 1;
    slot_num = 8'(s); preamble_len = 8'(pre); pkt_bytes = 5'(by); turnaround = 8'(ta);
    @(negedge clk); tx_req = 1'b1;
    @(posedge clk);
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (tx_go) begin seen = 1; break; end
      if (rx_en) rx++;
      tick_100us = (c % 3 == 0);
      if (tick_100us) n++;
    end
    tick_100us = 1'b0;
    chk(seen, "R4 slot go seen", int'(seen), 1);
    chk(n == expw, "R4 slot ticks", n, expw);
    chk(rx == 0, "R4 rx_en off in slot mode", rx, 0);
    release_req();
  endtask

  task automatic t_listen();
    int gos = 0, low = 0;
    mode_listen = 1; mode_delay = 0; chan_busy = 1'b1;
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_go) gos++;
      if (!rx_en) low++;
    end
    chk(gos == 0, "R5 no go while busy", gos, 0);
    chk(low == 0, "R5 rx_en while sensing", low, 0);
    chan_busy = 1'b0;
    @(negedge clk);
    chk(tx_go == 1'b1, "R5 go after clear", tx_go, 1);
    release_req();
  endtask

  task automatic t_backoff();
    int d, rounds = 0, gos = 0;
    bit ok_grid = 1, ok_max = 1, done;
    mode_listen = 1; mode_delay = 1; backoff_exp = 3'd3;
    chan_busy = 1'b1; tick_100us = 1'b1;
    @(negedge clk); tx_req = 1'b1;
    for (int i = 0; i < 2000 && rounds < 4; i++) begin
      @(negedge clk);
      if (tx_go) gos++;
      if (!rx_en) begin
        d = 0; done = 0;
        for (int k = 0; k < 200 && !done; k++) begin
          d++;
          @(negedge clk);
          if (tx_go) gos++;
          if (rx_en) done = 1;
        end
        if (d % 10 != 0) ok_grid = 0;
        if (d > 70 || d < 10) ok_max = 0;
        if (!ok_grid || !ok_max) $display("FAIL R6 back-off length actual=%0d expected=10..70 step 10", d);
        rounds++;
      end
    end
    chk(rounds == 4, "R6 back-off rounds observed", rounds, 4);
    chk(ok_grid, "R6 back-off multiple of 10 ticks", int'(ok_grid), 1);
    chk(ok_max, "R6 back-off within 2^N-1 ms", int'(ok_max), 1);
    chk(gos == 0, "R6 no go while busy", gos, 0);
    chan_busy = 1'b0;
    done = 0;
    for (int i = 0; i < 100 && !done; i++) begin
      @(negedge clk);
      if (tx_go) done = 1;
    end
    chk(done, "R6 go after channel clears", int'(done), 1);
    release_req();
  endtask

  task automatic t_zero_exp();
    int low = 0;
    mode_listen = 1; mode_delay = 1; backoff_exp = 3'd0;
    chan_busy = 1'b1; tick_100us = 1'b1;
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!rx_en) low++;
    end
    chk(low == 0, "R7 rx_en stays high with N=0", low, 0);
    chan_busy = 1'b0;
    @(negedge clk);
    chk(tx_go == 1'b1, "R7 go on first clear sample", tx_go, 1);
    release_req();
    backoff_exp = 3'd3;
  endtask

  task automatic t_abort_slot();
    int gos = 0;
    mode_listen = 0; mode_delay = 1;
    slot_num = 8'd5; preamble_len = 8'd10; pkt_bytes = 5'd4; turnaround = 8'd2;
    tick_100us = 1'b1;
    @(negedge clk); tx_req = 1'b1;
    repeat (20) @(negedge clk);
    tx_req = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (tx_go) gos++;
    end
    chk(gos == 0, "R8 abort slot wait", gos, 0);
    tick_100us = 1'b0;
    mode_delay = 0;
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk);
    chk(tx_go == 1'b1, "R8 idle after abort", tx_go, 1);
    release_req();
  endtask

  task automatic t_abort_sense();
    mode_listen = 1; mode_delay = 0; chan_busy = 1'b1;
    @(negedge clk); tx_req = 1'b1;
    repeat (5) @(negedge clk);
    chk(rx_en == 1'b1, "R5 sensing before abort", rx_en, 1);
    tx_req = 1'b0;
    @(negedge clk);
    chk(rx_en == 1'b0, "R8 rx_en off after abort", rx_en, 0);
    chan_busy = 1'b0;
    repeat (5) @(negedge clk);
    chk(tx_go == 1'b0, "R8 no go after abort", tx_go, 0);
    release_req();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_immediate();
    t_slot(2, 3, 1, 1);
    t_slot(1, 1, 1, 1);
    t_slot(0, 20, 10, 30);
    t_slot(3, 17, 7, 4);
    t_listen();
    t_backoff();
    t_zero_exp();
    t_abort_slot();
    t_abort_sense();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule